// File: doc/BRIEF.md
# Prefix-Ordered Ternary Lookup Pipeline

This block resolves a 32-bit destination address to an output port number. Every stored row holds a ternary pattern, made of a value word and a care mask, plus a valid flag. The incoming address is compared against all rows at once. A priority selector then picks the matching row with the lowest index, and that index reads a per-row port memory. The result comes out three pipeline registers later, together with a hit flag and the winning row index. A new lookup can be accepted on every clock.

The priority comes only from where a row sits, with no length compare. The writer places longer prefixes at lower row indices. Rows are grouped by their number of trailing don't-care bits, with the group of zero such bits at row 0. The topmost match is therefore the longest prefix. As an example, the route 9.20.0.0 with mask 255.255.128.0 is stored as value 0x0914_0000 and care mask 0xFFFF_8000.

Rows are loaded one at a time through a row-addressed write port. The same port clears a row. Choosing which row to replace is left to an outside controller, which can use the reported row index.

Top module: `tlk_lookup_top`

## Requirements
- R1: A cycle with `rst` high at a clock edge clears every row's valid flag and the whole pipeline. After reset, `res_valid`, `res_hit`, `res_row` and `res_port` are all 0, and every lookup misses until a row is loaded with `wr_keep`=1.
- R2: A row matches an address exactly when its valid flag is set and ((addr XOR value) AND mask) is zero. Address bits or stored value bits where the mask bit is 0 have no effect on the match.
- R3: When several rows match, the one with the lowest row index wins. Row 0 has the highest priority.
- R4: On a hit, `res_hit`=1, `res_row` is the index of the winning row, and `res_port` is the port word last written to that row.
- R5: When no row matches, `res_hit`=0, `res_port`=0 and `res_row`=0 while `res_valid`=1.
- R6: A lookup sampled with `lk_valid`=1 at clock edge k gives `res_valid`=1 for exactly the one cycle after edge k+2. A lookup can be accepted at every edge. While `res_valid`=0, `res_hit` and `res_port` are 0.
- R7: When `wr_en`=1 at an edge, row `wr_row` is loaded with `wr_value`, `wr_mask` and `wr_port`, and its valid flag is set to `wr_keep`. With `wr_keep`=0 the row is cleared and never matches.
- R8: A write at the same edge as a lookup does not change that lookup's match or its port. Lookups sampled at later edges see the write in both the match and the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Destination address to resolve |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 6 | Row index being written |
| wr_keep | input | 1 | 1 loads the row as valid, 0 clears it |
| wr_value | input | 32 | Pattern value |
| wr_mask | input | 32 | Care mask, ones over the prefix bits |
| wr_port | input | 8 | Port number stored for the row |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Some row matched |
| res_row | output | 6 | Winning row index (0 on miss) |
| res_port | output | 8 | Port of winning row (0 on miss) |

## Verification
A bad stored value, mask or valid flag shows as a wrong hit or wrong row on the first lookup that touches that row, three cycles after that lookup is accepted. A stale or misaligned port memory shows as a correct row paired with a wrong port. It is exposed by rewriting a row's port in the same cycle as a lookup, and again one cycle later. A broken priority walk shows only when overlapping prefixes are loaded, so nested routes are placed at several depths. A pipeline valid that is slipped or stuck shows as a result arriving early, late or unrequested in the very next cycle.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  localparam int TLK_ADDR_W_DEF = 32;
  localparam int TLK_ROWS_DEF   = 64;
  localparam int TLK_PORT_W_DEF = 8;

  // Writes to the port memory trail the ternary rows by this many registers,
  // so that a lookup in flight reads the port word of its own acceptance time.
  localparam int TLK_PORT_WR_LAG = 2;
endpackage

// File: rtl/tlk_tcam_array.sv
module tlk_tcam_array #(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 64,
  parameter int IDX_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic              wr_keep,
  input  logic [ADDR_W-1:0] wr_value,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              s1_valid,
  output logic [ROWS-1:0]   s1_match
);
  logic [ADDR_W-1:0] val_q [ROWS];
  logic [ADDR_W-1:0] msk_q [ROWS];
  logic [ROWS-1:0]   vld_q;
  logic [ROWS-1:0]   match_w;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic sel_w;
    assign sel_w = wr_en && (wr_row == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (sel_w) begin
        val_q[r] <= wr_value & wr_mask;
        msk_q[r] <= wr_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) vld_q[r] <= 1'b0;
      else if (sel_w) vld_q[r] <= wr_keep;
    end

    assign match_w[r] = vld_q[r] && (((lk_addr ^ val_q[r]) & msk_q[r]) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_match <= '0;
    end else begin
      s1_valid <= lk_valid;
      s1_match <= lk_valid ? match_w : '0;
    end
  end
endmodule

// File: rtl/tlk_prio_sel.sv
module tlk_prio_sel #(
  parameter int ROWS  = 64,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [ROWS-1:0]  s1_match,
  output logic             s2_valid,
  output logic             s2_hit,
  output logic [IDX_W-1:0] s2_row
);
  logic             any_w;
  logic [IDX_W-1:0] idx_w;

  // Walk from the bottom up so the lowest matching index is the last to land.
  always_comb begin
    any_w = 1'b0;
    idx_w = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (s1_match[r]) begin
        any_w = 1'b1;
        idx_w = IDX_W'(r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_hit   <= 1'b0;
      s2_row   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_hit   <= s1_valid && any_w;
      s2_row   <= (s1_valid && any_w) ? idx_w : '0;
    end
  end
endmodule

// File: rtl/tlk_port_mem.sv
module tlk_port_mem #(
  parameter int ROWS   = 64,
  parameter int IDX_W  = $clog2(ROWS),
  parameter int PORT_W = 8,
  parameter int LAG    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              s2_valid,
  input  logic              s2_hit,
  input  logic [IDX_W-1:0]  s2_row,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_row,
  output logic [PORT_W-1:0] res_port
);
  logic [PORT_W-1:0] mem [ROWS];
  logic [PORT_W-1:0] rd_q;
  logic              lag_en   [LAG+1];
  logic [IDX_W-1:0]  lag_row  [LAG+1];
  logic [PORT_W-1:0] lag_port [LAG+1];

  assign lag_en[0]   = wr_en;
  assign lag_row[0]  = wr_row;
  assign lag_port[0] = wr_port;

  for (genvar s = 1; s <= LAG; s++) begin : g_lag
    always_ff @(posedge clk) begin
      if (rst) lag_en[s] <= 1'b0;
      else     lag_en[s] <= lag_en[s-1];
      lag_row[s]  <= lag_row[s-1];
      lag_port[s] <= lag_port[s-1];
    end
  end

  // Simple dual-port memory, read-first on a shared edge.
  always_ff @(posedge clk) begin
    if (lag_en[LAG]) mem[lag_row[LAG]] <= lag_port[LAG];
  end

  always_ff @(posedge clk) begin
    if (s2_valid) rd_q <= mem[s2_row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_row   <= '0;
    end else begin
      res_valid <= s2_valid;
      res_hit   <= s2_valid && s2_hit;
      res_row   <= (s2_valid && s2_hit) ? s2_row : '0;
    end
  end

  assign res_port = res_hit ? rd_q : '0;
endmodule

// File: rtl/tlk_lookup_top.sv
module tlk_lookup_top
  import tlk_pkg::*;
#(
  parameter int ADDR_W = TLK_ADDR_W_DEF,
  parameter int ROWS   = TLK_ROWS_DEF,
  parameter int PORT_W = TLK_PORT_W_DEF,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic              wr_keep,
  input  logic [ADDR_W-1:0] wr_value,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic [PORT_W-1:0] wr_port,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_row,
  output logic [PORT_W-1:0] res_port
);
  logic             s1_valid;
  logic [ROWS-1:0]  s1_match;
  logic             s2_valid;
  logic             s2_hit;
  logic [IDX_W-1:0] s2_row;

  tlk_tcam_array #(.ADDR_W(ADDR_W), .ROWS(ROWS), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_row(wr_row), .wr_keep(wr_keep),
    .wr_value(wr_value), .wr_mask(wr_mask),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .s1_valid(s1_valid), .s1_match(s1_match)
  );

  tlk_prio_sel #(.ROWS(ROWS), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_match(s1_match),
    .s2_valid(s2_valid), .s2_hit(s2_hit), .s2_row(s2_row)
  );

  tlk_port_mem #(.ROWS(ROWS), .IDX_W(IDX_W), .PORT_W(PORT_W), .LAG(TLK_PORT_WR_LAG)) u_pmem (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_row(wr_row), .wr_port(wr_port),
    .s2_valid(s2_valid), .s2_hit(s2_hit), .s2_row(s2_row),
    .res_valid(res_valid), .res_hit(res_hit), .res_row(res_row), .res_port(res_port)
  );
endmodule

// File: rtl/tlk_lookup_chk.sv
module tlk_lookup_chk #(
  parameter int IDX_W  = 6,
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              wr_en,
  input logic              wr_keep,
  input logic              res_valid,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_row,
  input logic [PORT_W-1:0] res_port
);
  logic [2:0] vsh;
  logic       loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh    <= '0;
      loaded <= 1'b0;
    end else begin
      vsh    <= {vsh[1:0], lk_valid};
      loaded <= loaded || (wr_en && wr_keep);
    end
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid == vsh[2]);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && res_port == '0));

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_port == '0 && res_row == '0));

  a_r1_empty_miss: assert property (@(posedge clk) disable iff (rst)
    !loaded |-> !res_hit);
endmodule

bind tlk_lookup_top tlk_lookup_chk #(.IDX_W(IDX_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .wr_en(wr_en), .wr_keep(wr_keep),
  .res_valid(res_valid), .res_hit(res_hit), .res_row(res_row), .res_port(res_port)
);

// File: tb/tlk_lookup_top_tb.sv
module tlk_lookup_top_tb;
  localparam int ROWS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_row = '0;
  logic        wr_keep = 1'b0;
  logic [31:0] wr_value = '0;
  logic [31:0] wr_mask = '0;
  logic [7:0]  wr_port = '0;
  logic        res_valid, res_hit;
  logic [5:0]  res_row;
  logic [7:0]  res_port;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_val [ROWS];
  logic [31:0] m_msk [ROWS];
  logic [7:0]  m_port [ROWS];
  logic        m_vld [ROWS];

  logic [14:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  tlk_lookup_top u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_row(wr_row), .wr_keep(wr_keep),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_port(wr_port),
    .res_valid(res_valid), .res_hit(res_hit), .res_row(res_row), .res_port(res_port)
  );

  function automatic logic [14:0] model(input logic [31:0] a);
    for (int r = 0; r < ROWS; r++)
      if (m_vld[r] && (((a ^ m_val[r]) & m_msk[r]) == 32'h0))
        return {1'b1, 6'(r), m_port[r]};
    return 15'h0;
  endfunction

  task automatic set_write(input int row, input bit keep, input logic [31:0] v,
                           input logic [31:0] m, input logic [7:0] p);
    wr_en = 1'b1; wr_row = 6'(row); wr_keep = keep;
    wr_value = v; wr_mask = m; wr_port = p;
  endtask

  task automatic commit_write(input int row, input bit keep, input logic [31:0] v,
                              input logic [31:0] m, input logic [7:0] p);
    m_vld[row] = keep; m_val[row] = v; m_msk[row] = m; m_port[row] = p;
  endtask

  task automatic do_write(input int row, input bit keep, input logic [31:0] v,
                          input logic [31:0] m, input logic [7:0] p);
    @(negedge clk);
    lk_valid = 1'b0;
    set_write(row, keep, v, m, p);
    commit_write(row, keep, v, m, p);
  endtask

  task automatic do_lookup(input logic [31:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(model(a)); tag_q.push_back(tag);
  endtask

  task automatic do_both(input logic [31:0] a, input string tag, input int row,
                         input logic [31:0] v, input logic [31:0] m, input logic [7:0] p);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(model(a)); tag_q.push_back(tag);
    set_write(row, 1'b1, v, m, p);
    commit_write(row, 1'b1, v, m, p);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare each produced result.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R6 unexpected result actual=%b expected=no result", res_valid);
        end else begin
          logic [14:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({res_hit, res_row, res_port} !== e) begin
            failures++;
            $display("FAIL %s actual hit=%b row=%0d port=%h expected hit=%b row=%0d port=%h",
                     t, res_hit, res_row, res_port, e[14], e[13:8], e[7:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      m_vld[r] = 1'b0; m_val[r] = '0; m_msk[r] = '0; m_port[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({res_valid, res_hit, res_row, res_port} !== 16'h0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%h expected=0000",
               {res_valid, res_hit, res_row, res_port});
    end

    do_lookup(32'h0914_0001, "R1 empty table miss");
    do_lookup(32'hFFFF_FFFF, "R5 empty table miss");

    do_write(10, 1'b1, 32'h0914_0000, 32'hFFFF_8000, 8'h21);
    do_lookup(32'h0914_0001, "R4 /17 hit");
    do_lookup(32'h0914_8001, "R5 outside /17 miss");
    do_lookup(32'h0914_7FFF, "R2 top of /17 hit");

    do_write(2, 1'b1, 32'h0914_0500, 32'hFFFF_FF00, 8'h42);
    do_write(40, 1'b1, 32'h0900_0000, 32'hFF00_0000, 8'h77);
    do_write(0, 1'b1, 32'h0914_0507, 32'hFFFF_FFFF, 8'h05);
    do_lookup(32'h0914_0507, "R3 /32 wins at row 0");
    do_lookup(32'h0914_0508, "R3 /24 over /17 and /8");
    do_lookup(32'h0914_1000, "R3 /17 over /8");
    do_lookup(32'h0901_0101, "R3 only /8");

    do_write(20, 1'b1, 32'h0B0B_00FF, 32'hFFFF_0000, 8'h31);
    do_lookup(32'h0B0B_1234, "R2 masked value bits ignored");
    do_lookup(32'h0B0A_1234, "R2 cared bit differs miss");

    do_write(2, 1'b0, 32'h0914_0500, 32'hFFFF_FF00, 8'h42);
    do_lookup(32'h0914_0508, "R7 cleared row falls to /17");

    do_write(63, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'hEE);
    do_lookup(32'h0B0A_1234, "R3 default route catches");
    do_lookup(32'h0914_0507, "R3 row 0 beats default");

    do_both(32'h0914_0001, "R8 same-cycle write not seen", 10,
            32'h0914_0000, 32'hFFFF_8000, 8'h99);
    do_lookup(32'h0914_0001, "R8 next lookup sees new port");
    do_both(32'h0C00_0001, "R8 new row not matched in same cycle", 5,
            32'h0C00_0000, 32'hFF00_0000, 8'h3C);
    do_lookup(32'h0C00_0001, "R8 new row matched next cycle");

    for (int i = 0; i < 16; i++)
      do_lookup(32'h0914_0000 + 32'(i * 32'h0000_0F01), "R6 back-to-back stream");
    idle(8);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R6 results missing actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule